// File: doc/BRIEF.md
# Parallel Flash Command Interpreter

This block is the command engine of a parallel NOR flash model, attached to a simple synchronous memory bus. Bus writes are not stored directly. Each one is decoded as a step of a command sequence. Depending on the sequence, a write changes the read mode, clears or updates the status register, erases one sector of the internal byte array, or programs bus-width words through a counted buffered-write phase. The buffered-write phase ends with a confirm code.

Bus reads are registered. The data returned depends on the current mode: array words assembled little-endian from the internal storage, the status register zero-extended to the bus width, or one byte of a built-in device query table. The bus width (1, 2 or 4 bytes), the sector size and the sector count are parameters. The default is a 2-byte bus with 4 sectors of 256 bytes, which gives a 10-bit byte address.

Top module: `flash_cmd_engine`

## Requirements
- R1: After reset every array byte reads 0xFF, the status register is zero, and the block is in array-read mode.
- R2: In array-read or status-read mode, a written low byte is a command. 0x70 selects status-read mode and 0x98 selects query mode. 0xFF, 0x00 and any unrecognised value select array-read mode.
- R3: Command 0x50 clears the whole status register to zero and selects array-read mode.
- R4: Block erase is 0x20 followed by 0xD0. The confirm write's address, with its sector-offset bits cleared, picks the sector. Every byte of that sector becomes 0xFF and other sectors are unchanged. Status bit 7 is set and the block enters status-read mode. Any other second value erases nothing and selects array-read mode.
- R5: Buffered write is 0xE8, then a count byte N, then N+1 data writes. Each data write stores the whole bus word at its aligned address, with byte k of the word at address+k. Status bit 7 is set by 0xE8 and by each data write.
- R6: After the data phase, 0xD0 selects status-read mode. Any other value selects array-read mode. In both cases the data already written stays stored.
- R7: Lock/unlock is 0x60 followed by 0xD0 or 0x01, which sets status bit 7 and selects status-read mode. Any other second value selects array-read mode and leaves the status unchanged.
- R8: While an erase, lock or buffered-write sequence is pending, and in status-read mode, reads return the status register in the low byte with zeros above.
- R9: In query mode the table index is the low 8 address bits shifted right by log2 of the bus width. Indices 0x10, 0x11 and 0x12 return 0x51, 0x52 and 0x59. Index 0x27 returns log2 of the array size in bytes. Index 0x2D returns the sector count minus one. Indices above 0x51 return zero.
- R10: In query mode, a written 0xFF selects array-read mode. Any other written value leaves the block in query mode.
- R11: Array reads ignore the address bits below the bus width and return the aligned word.
- R12: Read data is updated on the clock edge at which the read strobe is high and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | ADDR_W (10) | Byte address |
| busWr | input | 1 | Write strobe, one cycle per bus write |
| busWrData | input | 8*BUS_BYTES (16) | Write data; command codes in bits 7:0 |
| busRd | input | 1 | Read strobe |
| busRdData | output | 8*BUS_BYTES (16) | Registered read data |

## Verification
The hardest states to reach are the ends of the buffered-write sequence. The counted data phase must run out exactly on its last word before the confirm code is even looked at. The data written before an aborted confirm must survive. The stimulus drives a full three-word buffered write that spans two sectors, then erases one of them, so that one run shows both the erase boundary and the stored words. A separate one-word buffered write, closed with a wrong confirm code, shows that data survives an abort. Mode checks are made by reading the same address before and after each command, because array data, the status value and the query bytes are chosen to differ.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  localparam logic [7:0] CMD_ERASE   = 8'h20;
  localparam logic [7:0] CMD_CLEAR   = 8'h50;
  localparam logic [7:0] CMD_LOCK    = 8'h60;
  localparam logic [7:0] CMD_STATUS  = 8'h70;
  localparam logic [7:0] CMD_QUERY   = 8'h98;
  localparam logic [7:0] CMD_BUFFER  = 8'hE8;
  localparam logic [7:0] CMD_ARRAY   = 8'hFF;
  localparam logic [7:0] CMD_CONFIRM = 8'hD0;
  localparam logic [7:0] CMD_LOCKSET = 8'h01;
  localparam int         READY_BIT   = 7;
  localparam int         COUNT_W     = 8;
  localparam logic [7:0] QUERY_LAST  = 8'h51;

  typedef enum logic [1:0] {RD_ARRAY, RD_STATUS, RD_QUERY} rd_sel_e;

  typedef enum logic [2:0] {
    ST_ARRAY, ST_STATUS, ST_QUERY, ST_ERASE_ARM,
    ST_LOCK_ARM, ST_BUF_COUNT, ST_BUF_DATA, ST_BUF_CONFIRM
  } cmd_state_e;

  typedef struct packed {
    logic       eraseGo;
    logic       storeGo;
    rd_sel_e    readSel;
    logic [7:0] status;
  } ctrl_strb_t;

endpackage

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import flash_cmd_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       busWr,
  input  logic [7:0] cmdByte,
  output ctrl_strb_t strb
);

  cmd_state_e         state, nextState;
  logic [7:0]         statusQ, statusNext;
  logic [COUNT_W-1:0] countQ, countNext;
  logic               eraseGo, storeGo;

  always_comb begin
    nextState  = state;
    statusNext = statusQ;
    countNext  = countQ;
    eraseGo    = 1'b0;
    storeGo    = 1'b0;
    if (busWr) begin
      case (state)
        ST_ARRAY, ST_STATUS: begin
          case (cmdByte)
            CMD_ERASE:  nextState = ST_ERASE_ARM;
            CMD_CLEAR:  begin statusNext = '0; nextState = ST_ARRAY; end
            CMD_LOCK:   nextState = ST_LOCK_ARM;
            CMD_STATUS: nextState = ST_STATUS;
            CMD_QUERY:  nextState = ST_QUERY;
            CMD_BUFFER: begin
              statusNext[READY_BIT] = 1'b1;
              nextState = ST_BUF_COUNT;
            end
            default:    nextState = ST_ARRAY;
          endcase
        end
        ST_ERASE_ARM: begin
          if (cmdByte == CMD_CONFIRM) begin
            eraseGo = 1'b1;
            statusNext[READY_BIT] = 1'b1;
            nextState = ST_STATUS;
          end else begin
            nextState = ST_ARRAY;
          end
        end
        ST_LOCK_ARM: begin
          if (cmdByte == CMD_CONFIRM || cmdByte == CMD_LOCKSET) begin
            statusNext[READY_BIT] = 1'b1;
            nextState = ST_STATUS;
          end else begin
            nextState = ST_ARRAY;
          end
        end
        ST_QUERY: begin
          if (cmdByte == CMD_ARRAY) nextState = ST_ARRAY;
        end
        ST_BUF_COUNT: begin
          countNext = cmdByte;
          nextState = ST_BUF_DATA;
        end
        ST_BUF_DATA: begin
          storeGo = 1'b1;
          statusNext[READY_BIT] = 1'b1;
          if (countQ == '0) nextState = ST_BUF_CONFIRM;
          else countNext = countQ - 1'b1;
        end
        ST_BUF_CONFIRM: begin
          nextState = (cmdByte == CMD_CONFIRM) ? ST_STATUS : ST_ARRAY;
        end
        default: nextState = ST_ARRAY;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_ARRAY;
      statusQ <= '0;
      countQ  <= '0;
    end else begin
      state   <= nextState;
      statusQ <= statusNext;
      countQ  <= countNext;
    end
  end

  always_comb begin
    strb.eraseGo = eraseGo;
    strb.storeGo = storeGo;
    strb.status  = statusQ;
    case (state)
      ST_ARRAY: strb.readSel = RD_ARRAY;
      ST_QUERY: strb.readSel = RD_QUERY;
      default:  strb.readSel = RD_STATUS;
    endcase
  end

endmodule

// File: rtl/flash_cmd_array.sv
module flash_cmd_array
  import flash_cmd_pkg::*;
#(
  parameter int BUS_BYTES    = 2,
  parameter int SECTOR_BYTES = 256,
  parameter int NUM_SECTORS  = 4,
  localparam int TOTAL_BYTES = SECTOR_BYTES * NUM_SECTORS,
  localparam int ADDR_W      = $clog2(TOTAL_BYTES),
  localparam int DATA_W      = 8 * BUS_BYTES
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWrData,
  input  logic              busRd,
  input  ctrl_strb_t        strb,
  output logic [DATA_W-1:0] busRdData
);

  localparam int LANE_BITS = $clog2(BUS_BYTES);
  localparam logic [ADDR_W-1:0] LANE_MASK = ~ADDR_W'(BUS_BYTES - 1);
  localparam logic [ADDR_W-1:0] SECT_MASK = ~ADDR_W'(SECTOR_BYTES - 1);
  localparam logic [15:0] SECT_M1 = 16'(NUM_SECTORS - 1);
  localparam logic [23:0] SECT_SZ = 24'(SECTOR_BYTES);
  localparam logic [7:0]  SIZE_LOG = 8'($clog2(TOTAL_BYTES));

  logic [7:0]        mem [TOTAL_BYTES];
  logic [ADDR_W-1:0] alignedAddr, sectorBase;
  logic [DATA_W-1:0] arrayWord;
  logic [7:0]        queryIdx;

  assign alignedAddr = busAddr & LANE_MASK;
  assign sectorBase  = busAddr & SECT_MASK;
  assign queryIdx    = busAddr[7:0] >> LANE_BITS;

  function automatic logic [7:0] queryByte(input logic [7:0] idx);
    logic [7:0] v;
    case (idx)
      8'h10: v = 8'h51;
      8'h11: v = 8'h52;
      8'h12: v = 8'h59;
      8'h13: v = 8'h01;
      8'h15: v = 8'h31;
      8'h1B: v = 8'h45;
      8'h1C: v = 8'h55;
      8'h27: v = SIZE_LOG;
      8'h28: v = 8'h02;
      8'h2A: v = 8'h04;
      8'h2C: v = 8'h01;
      8'h2D: v = SECT_M1[7:0];
      8'h2E: v = SECT_M1[15:8];
      8'h2F: v = SECT_SZ[15:8];
      8'h30: v = SECT_SZ[23:16];
      8'h31: v = 8'h50;
      8'h32: v = 8'h52;
      8'h33: v = 8'h49;
      8'h34: v = 8'h31;
      8'h35: v = 8'h31;
      default: v = 8'h00;
    endcase
    if (idx > QUERY_LAST) v = 8'h00;
    return v;
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int b = 0; b < TOTAL_BYTES; b++) mem[b] <= 8'hFF;
    end else begin
      for (int b = 0; b < TOTAL_BYTES; b++) begin
        if (strb.eraseGo && ((ADDR_W'(b) & SECT_MASK) == sectorBase))
          mem[b] <= 8'hFF;
        else if (strb.storeGo && ((ADDR_W'(b) & LANE_MASK) == alignedAddr))
          mem[b] <= busWrData[8*(b % BUS_BYTES) +: 8];
      end
    end
  end

  always_comb begin
    for (int i = 0; i < BUS_BYTES; i++)
      arrayWord[8*i +: 8] = mem[alignedAddr + ADDR_W'(i)];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busRdData <= '0;
    end else if (busRd) begin
      case (strb.readSel)
        RD_ARRAY: busRdData <= arrayWord;
        RD_QUERY: busRdData <= DATA_W'(queryByte(queryIdx));
        default:  busRdData <= DATA_W'(strb.status);
      endcase
    end
  end

endmodule

// File: rtl/flash_cmd_engine.sv
module flash_cmd_engine
  import flash_cmd_pkg::*;
#(
  parameter int BUS_BYTES    = 2,
  parameter int SECTOR_BYTES = 256,
  parameter int NUM_SECTORS  = 4,
  localparam int ADDR_W      = $clog2(SECTOR_BYTES * NUM_SECTORS),
  localparam int DATA_W      = 8 * BUS_BYTES
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic [DATA_W-1:0] busWrData,
  input  logic              busRd,
  output logic [DATA_W-1:0] busRdData
);

  ctrl_strb_t strb;

  flash_cmd_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .busWr   (busWr),
    .cmdByte (busWrData[7:0]),
    .strb    (strb)
  );

  flash_cmd_array #(
    .BUS_BYTES    (BUS_BYTES),
    .SECTOR_BYTES (SECTOR_BYTES),
    .NUM_SECTORS  (NUM_SECTORS)
  ) u_array (
    .clk       (clk),
    .rstN      (rstN),
    .busAddr   (busAddr),
    .busWrData (busWrData),
    .busRd     (busRd),
    .strb      (strb),
    .busRdData (busRdData)
  );

endmodule

// File: rtl/flash_cmd_engine_chk.sv
module flash_cmd_engine_chk
  import flash_cmd_pkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic       busWr,
  input logic [7:0] cmdByte,
  input logic       eraseGo,
  input logic       storeGo,
  input logic       readyBit,
  input rd_sel_e    readSel
);

  // R4
  erase_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    eraseGo |=> readyBit);

  // R4
  erase_code_chk: assert property (@(posedge clk) disable iff (!rstN)
    eraseGo |-> (busWr && cmdByte == CMD_CONFIRM));

  // R5
  store_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    storeGo |=> readyBit);

  // R5
  store_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    storeGo |-> busWr);

  // R10
  query_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (readSel == RD_QUERY && busWr && cmdByte != CMD_ARRAY) |=> readSel == RD_QUERY);

  // R10
  query_exit_chk: assert property (@(posedge clk) disable iff (!rstN)
    (readSel == RD_QUERY && busWr && cmdByte == CMD_ARRAY) |=> readSel == RD_ARRAY);

endmodule

bind flash_cmd_engine flash_cmd_engine_chk u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .busWr    (busWr),
  .cmdByte  (busWrData[7:0]),
  .eraseGo  (strb.eraseGo),
  .storeGo  (strb.storeGo),
  .readyBit (strb.status[7]),
  .readSel  (strb.readSel)
);

// File: tb/flash_cmd_engine_tb.sv
module flash_cmd_engine_tb;

  localparam int ADDR_W = 10;
  localparam int DATA_W = 16;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [ADDR_W-1:0] busAddr = '0;
  logic              busWr = 1'b0;
  logic [DATA_W-1:0] busWrData = '0;
  logic              busRd = 1'b0;
  logic [DATA_W-1:0] busRdData;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic rdLat = 1'b0;
  logic [DATA_W-1:0] expQ[$];
  string tagQ[$];

  always #2.5 clk = ~clk;

  flash_cmd_engine u_dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr),
    .busWrData(busWrData), .busRd(busRd), .busRdData(busRdData)
  );

  // monitor: compares the read word one edge after the strobe
  always @(posedge clk) rdLat <= busRd;

  always @(negedge clk) begin
    if (rdLat && expQ.size() > 0) begin
      logic [DATA_W-1:0] e;
      string t;
      e = expQ.pop_front();
      t = tagQ.pop_front();
      checks++;
      if (busRdData !== e) begin
        fails++;
        $display("FAIL %s: got %h expected %h", t, busRdData, e);
      end
    end
  end

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWr = 1'b1;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] e, input string t);
    @(negedge clk);
    busAddr = a; busRd = 1'b1;
    expQ.push_back(e);
    tagQ.push_back(t);
    @(negedge clk);
    busRd = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    rd(10'h000, 16'hFFFF, "R1 array after reset");
    rd(10'h3FE, 16'hFFFF, "R1 last word after reset");
    wr(10'h000, 16'h0070);
    rd(10'h000, 16'h0000, "R1 R2 status zero after reset");
    // R5 buffered write of three words
    wr(10'h100, 16'h00E8);
    rd(10'h100, 16'h0080, "R5 R8 ready after setup");
    wr(10'h100, 16'h0002);
    rd(10'h100, 16'h0080, "R8 status during data phase");
    wr(10'h104, 16'hBEEF);
    wr(10'h106, 16'h1234);
    wr(10'h200, 16'hA5A5);
    rd(10'h000, 16'h0080, "R8 status awaiting confirm");
    wr(10'h000, 16'h00D0);
    rd(10'h000, 16'h0080, "R6 confirm to status mode");
    wr(10'h000, 16'h00FF);
    rd(10'h104, 16'hBEEF, "R5 stored word");
    rd(10'h107, 16'h1234, "R11 low address bit ignored");
    rd(10'h200, 16'hA5A5, "R5 third word");
    // R3 clear status
    wr(10'h000, 16'h0050);
    rd(10'h104, 16'hBEEF, "R3 array mode after clear");
    wr(10'h000, 16'h0070);
    rd(10'h000, 16'h0000, "R3 status cleared");
    // R4 erase
    wr(10'h130, 16'h0020);
    rd(10'h000, 16'h0000, "R8 status while erase armed");
    wr(10'h1F0, 16'h00D0);
    rd(10'h104, 16'h0080, "R4 ready after erase");
    wr(10'h000, 16'h00FF);
    rd(10'h104, 16'hFFFF, "R4 sector erased");
    rd(10'h1FE, 16'hFFFF, "R4 sector top erased");
    rd(10'h200, 16'hA5A5, "R4 next sector kept");
    // R4 abort
    wr(10'h000, 16'h0050);
    wr(10'h200, 16'h0020);
    wr(10'h200, 16'h0033);
    rd(10'h200, 16'hA5A5, "R4 abort erases nothing");
    // R7 lock
    wr(10'h000, 16'h0060);
    wr(10'h000, 16'h00D0);
    rd(10'h200, 16'h0080, "R7 lock D0 ready");
    wr(10'h000, 16'h0050);
    wr(10'h000, 16'h0060);
    wr(10'h000, 16'h0001);
    rd(10'h200, 16'h0080, "R7 lock 01 ready");
    wr(10'h000, 16'h0050);
    wr(10'h000, 16'h0060);
    rd(10'h200, 16'h0000, "R8 status while lock armed");
    wr(10'h000, 16'h0042);
    rd(10'h200, 16'hA5A5, "R7 bad second value to array");
    wr(10'h000, 16'h0070);
    rd(10'h200, 16'h0000, "R7 status unchanged");
    // R9 query
    wr(10'h000, 16'h0098);
    rd(10'h020, 16'h0051, "R9 index 0x10");
    rd(10'h022, 16'h0052, "R9 index 0x11");
    rd(10'h024, 16'h0059, "R9 index 0x12");
    rd(10'h04E, 16'h000A, "R9 size log2");
    rd(10'h05A, 16'h0003, "R9 sectors minus one");
    rd(10'h0A4, 16'h0000, "R9 index beyond table");
    rd(10'h121, 16'h0051, "R9 only low address byte");
    // R10 query stays
    wr(10'h000, 16'h0070);
    rd(10'h020, 16'h0051, "R10 query kept");
    wr(10'h000, 16'h00FF);
    rd(10'h200, 16'hA5A5, "R10 query left");
    // R6 aborted confirm keeps data
    wr(10'h000, 16'h00E8);
    wr(10'h000, 16'h0000);
    wr(10'h000, 16'h0102);
    wr(10'h000, 16'h0077);
    rd(10'h000, 16'h0102, "R6 abort to array, data kept");
    // R2 reset codes
    wr(10'h000, 16'h0070);
    rd(10'h000, 16'h0080, "R2 status mode");
    wr(10'h000, 16'h0000);
    rd(10'h000, 16'h0102, "R2 code 00 to array");
    wr(10'h000, 16'h0070);
    wr(10'h000, 16'h0033);
    rd(10'h000, 16'h0102, "R2 unknown code to array");
    // R12 hold
    rd(10'h200, 16'hA5A5, "R12 read");
    @(negedge clk);
    busAddr = 10'h000;
    repeat (3) @(negedge clk);
    checks++;
    if (busRdData !== 16'hA5A5) begin
      fails++;
      $display("FAIL R12 hold: got %h expected %h", busRdData, 16'hA5A5);
    end
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end

endmodule